// File: doc/BRIEF.md
# Oscillator start-up delay controller

This block keeps the core from executing while a crystal or ceramic resonator settles. A count of rising edges on the raw oscillator input begins after a power-on reset, once the power-up timer reports done, or after a wake from sleep. Until the count finishes, the block stalls instruction fetch and holds the watchdog in reset. The counter is the same one the watchdog uses, so it is handed back to the watchdog only after the count ends.

Modes that need no settling time start without a count. These are the external clock input and the RC modes. One low-power case also skips the count on wake. In that case the secondary timer oscillator keeps the same low-power crystal circuit running through sleep. The decision is taken when sleep is entered, so that the wake-up path is already known.

The raw oscillator input is brought into the system clock domain through a synchronizer and an edge detector. All state is held in that domain.

Top module: `osc_start_delay`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `exec_stall` and `wdt_hold` are 1 and `clk_ready` is 0.
- R2: While `pwrt_done` is 0 after reset, rising edges on `osc_in` are not counted, and the stall remains. The full count starts only after `pwrt_done` is seen high.
- R3: For a crystal mode (`osc_mode` 0 = low-power, 1 = standard, 2 = high-speed), the stall is released after exactly 1024 rising edges of `osc_in`. `clk_ready` rises on the third `clk` edge after the 1024th rise of `osc_in`: two synchronizer stages, then the count register.
- R4: For a non-crystal mode (`osc_mode` 3 = external clock, 4 to 7 = RC), `clk_ready` rises one cycle after `pwrt_done` is seen high, and no oscillator edges are needed.
- R5: `wdt_hold` is 1 exactly while `exec_stall` is 1. `exec_stall` and `clk_ready` are never 1 together.
- R6: A one-cycle `sleep_enter` while running clears `clk_ready` in the next cycle, unless the skip condition holds. During sleep, `exec_stall` and `wdt_hold` are 0.
- R7: Skip condition: `osc_mode` = 0, `sec_osc_en` = 1, `clk_sel` = 0 (primary mode selected) and `on_primary` = 1. If it holds at sleep entry, `clk_ready` stays 1 through sleep, and a `wake` pulse returns to running with no count and no stall.
- R8: The skip condition is sampled only at sleep entry. Changes to its inputs during sleep do not affect the wake-up path.
- R9: If any one of the four skip terms is false at sleep entry, a crystal-mode `wake` starts a full 1024-edge count with stall and watchdog hold.
- R10: The counter is cleared when the stall is released, so every new count needs the full 1024 edges.
- R11: In a non-crystal mode, `wake` from sleep sets `clk_ready` in the next cycle.
- R12: `sleep_enter` while stalled, and `wake` while running, have no effect. This includes a `sleep_enter` in the same cycle as the terminating edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| osc_in | input | 1 | Raw oscillator input, asynchronous |
| osc_mode | input | 3 | Primary oscillator mode: 0 LP, 1 XT, 2 HS, 3 external clock, 4-7 RC |
| pwrt_done | input | 1 | Power-up timer expired (tie high if the timer is disabled) |
| sleep_enter | input | 1 | One-cycle sleep entry pulse |
| wake | input | 1 | One-cycle wake event pulse |
| sec_osc_en | input | 1 | Secondary timer oscillator enabled |
| clk_sel | input | 1 | Clock source select, 0 = configured primary mode |
| on_primary | input | 1 | Status: running from the primary clock |
| exec_stall | output | 1 | Hold the program counter |
| clk_ready | output | 1 | Oscillator start-up complete |
| wdt_hold | output | 1 | Keep the watchdog in reset |

## Verification
Two events can fall in the same cycle: the registering of the 1024th oscillator edge, which ends the count, and a sleep request. The bench raises `sleep_enter` exactly in the cycle where the synchronized edge is present. It then expects `clk_ready` to rise and to stay high afterwards, because the request was seen while still stalled. The bench also changes the skip inputs in the cycle after sleep entry, and judges the wake-up path against the value those inputs had when sleep was entered.

// File: rtl/osd_pkg.sv
package osd_pkg;

    localparam int CNT_W       = 10;
    localparam int SYNC_STAGES = 2;

    localparam logic [2:0] MODE_LP = 3'd0;
    localparam logic [2:0] MODE_XT = 3'd1;
    localparam logic [2:0] MODE_HS = 3'd2;

    typedef enum logic [1:0] {
        ST_PWRT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2,
        ST_SLEEP = 2'd3
    } osd_state_t;

    typedef struct packed {
        logic xtal;
        logic skip_now;
        logic sleep_req;
        logic wake_req;
        logic pwrt_ok;
    } osd_ctrl_t;

    function automatic logic is_crystal(input logic [2:0] mode);
        return (mode == MODE_LP) || (mode == MODE_XT) || (mode == MODE_HS);
    endfunction

    function automatic logic skip_ok(input logic [2:0] mode, input logic sec_en,
                                     input logic sel, input logic prim);
        return (mode == MODE_LP) && sec_en && !sel && prim;
    endfunction

endpackage

// File: rtl/osd_edge_sync.sv
module osd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= raw_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], raw_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/osd_counter.sv
module osd_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_top
);
    always_ff @(posedge clk) begin
        if (rst || clr) value <= '0;
        else if (inc)   value <= value + 1'b1;
    end

    assign at_top = &value;

    // R10
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && at_top) |=> (value == '0));

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (value == '0));
endmodule

// File: rtl/osd_fsm.sv
module osd_fsm
    import osd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  osd_ctrl_t  ctrl,
    input  logic       edge_hit,
    input  logic       cnt_top,
    output osd_state_t state,
    output logic       skip_l
);
    osd_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWRT:  if (ctrl.pwrt_ok)          nxt = ctrl.xtal ? ST_COUNT : ST_RUN;
            ST_COUNT: if (edge_hit && cnt_top)   nxt = ST_RUN;
            ST_RUN:   if (ctrl.sleep_req)        nxt = ST_SLEEP;
            ST_SLEEP: if (ctrl.wake_req)         nxt = (skip_l || !ctrl.xtal) ? ST_RUN : ST_COUNT;
            default:                             nxt = ST_PWRT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_PWRT;
            skip_l <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && ctrl.sleep_req)
                skip_l <= ctrl.skip_now;
        end
    end

    // R8
    skip_latched_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> $stable(skip_l));

    // R2
    pwrt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWRT && !ctrl.pwrt_ok) |=> (state == ST_PWRT));
endmodule

// File: rtl/osc_start_delay.sv
module osc_start_delay
    import osd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_in,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_done,
    input  logic       sleep_enter,
    input  logic       wake,
    input  logic       sec_osc_en,
    input  logic       clk_sel,
    input  logic       on_primary,
    output logic       exec_stall,
    output logic       clk_ready,
    output logic       wdt_hold
);
    localparam int DELAY = 1 << CNT_W;

    osd_ctrl_t         ctrl;
    osd_state_t        state;
    logic              skip_l;
    logic              osc_rise;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_top;
    logic              counting;

    assign ctrl.xtal      = is_crystal(osc_mode);
    assign ctrl.skip_now  = skip_ok(osc_mode, sec_osc_en, clk_sel, on_primary);
    assign ctrl.sleep_req = sleep_enter;
    assign ctrl.wake_req  = wake;
    assign ctrl.pwrt_ok   = pwrt_done;

    osd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (osc_in),
        .rise   (osc_rise)
    );

    assign counting = (state == ST_COUNT);

    osd_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (!counting),
        .inc    (counting && osc_rise),
        .value  (cnt_val),
        .at_top (cnt_top)
    );

    osd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .edge_hit (osc_rise),
        .cnt_top  (cnt_top),
        .state    (state),
        .skip_l   (skip_l)
    );

    assign exec_stall = (state == ST_PWRT) || (state == ST_COUNT);
    assign wdt_hold   = exec_stall;
    assign clk_ready  = (state == ST_RUN) || (state == ST_SLEEP && skip_l);

    // R5
    stall_ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(exec_stall && clk_ready));

    // R3
    ready_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_ready) && $past(state) == ST_COUNT) |-> $past(cnt_top && osc_rise));

    // R7
    skip_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && skip_l && wake) |=> (clk_ready && !exec_stall));

    // R6
    sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && sleep_enter && !ctrl.skip_now) |=> (!clk_ready && !exec_stall));

    // R3
    delay_size_chk: assert final (DELAY == 1024);
endmodule

// File: tb/sim_osc_start_delay.sv
`timescale 1ns/1ps
module sim_osc_start_delay;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_in = 1'b0;
    logic [2:0] osc_mode = 3'd1;
    logic pwrt_done = 1'b0;
    logic sleep_enter = 1'b0;
    logic wake = 1'b0;
    logic sec_osc_en = 1'b0;
    logic clk_sel = 1'b0;
    logic on_primary = 1'b0;
    logic exec_stall, clk_ready, wdt_hold;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    osc_start_delay u0 (
        .clk(clk), .rst(rst), .osc_in(osc_in), .osc_mode(osc_mode),
        .pwrt_done(pwrt_done), .sleep_enter(sleep_enter), .wake(wake),
        .sec_osc_en(sec_osc_en), .clk_sel(clk_sel), .on_primary(on_primary),
        .exec_stall(exec_stall), .clk_ready(clk_ready), .wdt_hold(wdt_hold)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] mode, input logic pw);
        @(negedge clk);
        rst = 1'b1; osc_mode = mode; pwrt_done = pw; osc_in = 1'b0;
        sleep_enter = 1'b0; wake = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            osc_in = 1'b1; repeat (2) @(negedge clk);
            osc_in = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    task automatic count_to_ready(input string req, input bit sleep_at_end);
        pulse(1023);
        chk(req, exec_stall, 1'b1);
        chk(req, clk_ready, 1'b0);
        osc_in = 1'b1;
        repeat (2) @(negedge clk);
        chk(req, exec_stall, 1'b1);
        if (sleep_at_end) sleep_enter = 1'b1;
        @(negedge clk);
        sleep_enter = 1'b0;
        chk(req, clk_ready, 1'b1);
        chk(req, exec_stall, 1'b0);
        chk("R5", wdt_hold, 1'b0);
        osc_in = 1'b0;
        repeat (2) @(negedge clk);
        if (sleep_at_end) chk("R12", clk_ready, 1'b1);
    endtask

    task automatic go_sleep();
        sleep_enter = 1'b1; @(negedge clk); sleep_enter = 1'b0;
    endtask

    task automatic do_wake();
        wake = 1'b1; @(negedge clk); wake = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; pwrt_done = 1'b0;
        chk("R1", exec_stall, 1'b1);
        chk("R1", wdt_hold, 1'b1);
        chk("R1", clk_ready, 1'b0);
        do_reset(3'd1, 1'b0);
        chk("R1", exec_stall, 1'b1);
        chk("R1", clk_ready, 1'b0);
    endtask

    task automatic t_pwrt_gate();
        pulse(1100);
        chk("R2", exec_stall, 1'b1);
        chk("R2", clk_ready, 1'b0);
        chk("R5", wdt_hold, 1'b1);
        pwrt_done = 1'b1;
        repeat (2) @(negedge clk);
        count_to_ready("R2", 1'b0);
    endtask

    task automatic t_modes();
        do_reset(3'd0, 1'b1);
        count_to_ready("R3", 1'b0);
        do_reset(3'd2, 1'b1);
        count_to_ready("R3", 1'b0);
    endtask

    task automatic t_nonxtal(input logic [2:0] mode);
        do_reset(mode, 1'b0);
        repeat (3) @(negedge clk);
        chk("R4", exec_stall, 1'b1);
        pwrt_done = 1'b1;
        @(negedge clk);
        chk("R4", clk_ready, 1'b1);
        chk("R4", exec_stall, 1'b0);
        go_sleep();
        chk("R11", clk_ready, 1'b0);
        do_wake();
        chk("R11", clk_ready, 1'b1);
    endtask

    task automatic t_sleep_count();
        do_reset(3'd1, 1'b1);
        count_to_ready("R3", 1'b0);
        go_sleep();
        chk("R6", clk_ready, 1'b0);
        chk("R6", exec_stall, 1'b0);
        chk("R6", wdt_hold, 1'b0);
        pulse(10);
        do_wake();
        chk("R10", exec_stall, 1'b1);
        chk("R5", wdt_hold, 1'b1);
        count_to_ready("R10", 1'b1);
        do_wake();
        chk("R12", clk_ready, 1'b1);
        chk("R12", exec_stall, 1'b0);
    endtask

    task automatic t_skip();
        do_reset(3'd0, 1'b1);
        count_to_ready("R3", 1'b0);
        sec_osc_en = 1'b1; clk_sel = 1'b0; on_primary = 1'b1;
        go_sleep();
        chk("R7", clk_ready, 1'b1);
        chk("R7", exec_stall, 1'b0);
        sec_osc_en = 1'b0;
        repeat (3) @(negedge clk);
        do_wake();
        chk("R8", clk_ready, 1'b1);
        chk("R7", exec_stall, 1'b0);
        go_sleep();
        sec_osc_en = 1'b1;
        do_wake();
        chk("R8", exec_stall, 1'b1);
        count_to_ready("R8", 1'b0);
    endtask

    task automatic t_skip_missing();
        on_primary = 1'b0;
        go_sleep();
        chk("R9", clk_ready, 1'b0);
        on_primary = 1'b1;
        do_wake();
        chk("R9", exec_stall, 1'b1);
        count_to_ready("R9", 1'b0);
        clk_sel = 1'b1;
        go_sleep();
        clk_sel = 1'b0;
        do_wake();
        chk("R9", exec_stall, 1'b1);
        count_to_ready("R9", 1'b0);
        osc_mode = 3'd1;
        go_sleep();
        do_wake();
        chk("R9", exec_stall, 1'b1);
        chk("R9", clk_ready, 1'b0);
        go_sleep();
        chk("R12", exec_stall, 1'b1);
        count_to_ready("R12", 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pwrt_gate();
        t_modes();
        t_nonxtal(3'd3);
        t_nonxtal(3'd5);
        t_sleep_count();
        t_skip();
        t_skip_missing();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule